// File: doc/BRIEF.md
# Variable-length codeword bit packer

This block sits at the tail of an entropy coder. Each cycle it may take one variable-length codeword, given as a value right-aligned in a 32-bit field together with a bit count. It concatenates the codewords with no gaps, most significant bit first, into a continuous bit stream. Each time the stream completes a 32-bit word, that word leaves on the output with a one-cycle valid strobe.

The block keeps a 5-bit fill position, counted modulo 32, and a 32-bit assembly register. A shifter moves each new codeword so that its first bit falls directly after the last bit already held. Adding the codeword length to the fill position gives a carry-out. The carry-out alone decides whether the assembled upper half leaves this cycle; on a carry, the spill-over bits of the lower half become the new assembly contents. At the end of a stream, a flush sends out the partial word with zero padding and returns the position to zero.

Top module: `vlc_word_packer`

## Requirements
- R1: After reset, `word_valid` is 0 and the fill position is 0, so a flush issued straight after reset emits no word.
- R2: Codeword bits are packed MSB-first. The first bit of the stream lands in bit 31 of an output word, and each codeword's bits follow the previous codeword's bits with no gap.
- R3: A word is emitted when the codeword presented in a cycle brings the bit count to 32 or more. `word_valid` is high for exactly the one cycle after that clock edge, and `word_out` is valid in that same cycle.
- R4: Bits of a codeword that do not fit in the word being completed form the leading bits of the next output word.
- R5: A codeword with length 0 changes nothing: no word is emitted and the fill position is kept.
- R6: Bits of `cw_bits` at positions at or above `cw_len` are ignored.
- R7: A flush issued with `cw_valid` low and a nonzero fill position emits the held bits in the upper bits of `word_out` with the unused low bits set to 0, and clears the fill position.
- R8: A flush issued with a fill position of 0 emits nothing.
- R9: A flush issued in the same cycle as `cw_valid` is ignored. The codeword is taken normally.
- R10: `cw_len` ranges from 0 to 32. A 32-bit codeword is accepted at any fill position and always completes a word.
- R11: In a cycle with neither `cw_valid` nor `flush`, no word is emitted, and the fill position and `word_out` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_valid | input | 1 | Codeword present this cycle |
| cw_bits | input | 32 | Codeword value, right-aligned |
| cw_len | input | 6 | Codeword length in bits, 0 to 32 |
| flush | input | 1 | Emit the pending partial word |
| word_out | output | 32 | Packed output word |
| word_valid | output | 1 | `word_out` holds a new word this cycle |

## Verification
The assertions take for granted that `cw_len` never exceeds 32 while `cw_valid` is high. The flush properties also assume the flush is judged only in cycles without a codeword. The bench drives only legal lengths, from 0 to 32, including a long deterministic pseudo-random run. It presents the flush both alone and together with a codeword, so that the ignored case is exercised while staying inside the assumed input range. Expected words come from a bit-serial model in the bench, which shifts in one bit at a time.

// File: rtl/vlc_word_packer.sv
module vlc_word_packer #(
  parameter int WORD_W = 32,
  localparam int POS_W = $clog2(WORD_W),
  localparam int LEN_W = POS_W + 1,
  localparam int SH_W  = POS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_bits,
  input  logic [LEN_W-1:0]  cw_len,
  input  logic              flush,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  logic [WORD_W-1:0]   hi_q;
  logic [POS_W-1:0]    pos_q;
  logic [2*WORD_W-1:0] len_mask;
  logic [2*WORD_W-1:0] cw_ext;
  logic [SH_W-1:0]     shamt;
  logic [2*WORD_W-1:0] placed;
  logic [2*WORD_W-1:0] pair;
  logic [LEN_W-1:0]    sum;
  logic                take;
  logic                carry;
  logic                drain;

  assign take     = cw_valid && (cw_len != '0);
  assign len_mask = ~({(2*WORD_W){1'b1}} << cw_len);
  assign cw_ext   = {{WORD_W{1'b0}}, cw_bits} & len_mask;
  assign shamt    = SH_W'(2*WORD_W) - SH_W'(pos_q) - SH_W'(cw_len);
  assign placed   = cw_ext << shamt;
  assign pair     = {hi_q, {WORD_W{1'b0}}} | placed;
  assign sum      = LEN_W'(pos_q) + cw_len;
  assign carry    = sum[LEN_W-1];
  assign drain    = !cw_valid && flush && (pos_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      pos_q      <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else if (take) begin
      pos_q      <= sum[POS_W-1:0];
      word_valid <= carry;
      if (carry) begin
        word_out <= pair[2*WORD_W-1:WORD_W];
        hi_q     <= pair[WORD_W-1:0];
      end else begin
        hi_q     <= pair[2*WORD_W-1:WORD_W];
      end
    end else if (drain) begin
      word_out   <= hi_q;
      word_valid <= 1'b1;
      hi_q       <= '0;
      pos_q      <= '0;
    end else begin
      word_valid <= 1'b0;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> cw_len <= LEN_W'(WORD_W)); // R10
  AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_len == LEN_W'(WORD_W)) |=> word_valid); // R10
  AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_len == '0) |=> (!word_valid && $stable(pos_q))); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw_valid && flush) |=> pos_q == '0); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw_valid && flush && pos_q == '0) |=> !word_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw_valid && !flush) |=> (!word_valid && $stable(pos_q) && $stable(word_out))); // R11

endmodule

// File: tb/sim_vlc_word_packer.sv
module sim_vlc_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0;
  logic [31:0] cw_bits = '0;
  logic [5:0]  cw_len = '0;
  logic        flush = 1'b0;
  logic [31:0] word_out;
  logic        word_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_q [0:255];
  int exp_wr = 0;
  int exp_rd = 0;
  logic [31:0] ref_acc = '0;
  int ref_cnt = 0;
  int seen = 0;
  logic [31:0] last_word = '0;

  always #10 clk = ~clk;

  vlc_word_packer u0 (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_bits(cw_bits),
    .cw_len(cw_len), .flush(flush), .word_out(word_out), .word_valid(word_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_push(input int len, input logic [31:0] bits);
    for (int i = len - 1; i >= 0; i--) begin
      ref_acc = {ref_acc[30:0], bits[i]};
      ref_cnt++;
      if (ref_cnt == 32) begin
        exp_q[exp_wr % 256] = ref_acc;
        exp_wr++;
        ref_cnt = 0;
      end
    end
  endtask

  task automatic model_flush();
    if (ref_cnt > 0) begin
      exp_q[exp_wr % 256] = ref_acc << (32 - ref_cnt);
      exp_wr++;
      ref_cnt = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      seen++;
      last_word = word_out;
      if (exp_rd < exp_wr) begin
        chk(word_out == exp_q[exp_rd % 256], "R2/R4 stream word", word_out, exp_q[exp_rd % 256]);
        exp_rd++;
      end else begin
        chk(1'b0, "R11 unexpected word", word_out, 32'h0);
      end
    end
  end

  task automatic send(input int len, input logic [31:0] bits);
    cw_valid = 1'b1;
    cw_len = 6'(len);
    cw_bits = bits;
    model_push(len, bits);
    @(posedge clk);
    @(negedge clk);
    cw_valid = 1'b0;
    cw_bits = '0;
    cw_len = '0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    model_flush();
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic drain_check(input string req);
    repeat (3) @(negedge clk);
    #1;
    chk(exp_rd == exp_wr, req, 32'(exp_rd), 32'(exp_wr));
  endtask

  task automatic t_reset();
    int s0;
    chk(word_valid == 1'b0, "R1 valid low after reset", 32'(word_valid), 32'h0);
    s0 = seen;
    do_flush();
    #1;
    chk(word_valid == 1'b0 && seen == s0, "R1/R8 flush at empty emits nothing", 32'(seen - s0), 32'h0);
  endtask

  task automatic t_basic();
    for (int i = 1; i <= 7; i++) begin
      send(4, 32'(i));
      chk(word_valid == 1'b0, "R3 no word before 32 bits", 32'(word_valid), 32'h0);
    end
    send(4, 32'h8);
    chk(word_valid == 1'b1 && word_out == 32'h12345678, "R2/R3 word in cycle after closing code", word_out, 32'h12345678);
    @(negedge clk);
    chk(word_valid == 1'b0, "R3 one-cycle strobe", 32'(word_valid), 32'h0);
    drain_check("R3 basic pending");
  endtask

  task automatic t_straddle();
    send(20, 32'hABCDE);
    send(20, 32'h12345);
    chk(word_valid && word_out == 32'hABCDE123, "R4 first straddle word", word_out, 32'hABCDE123);
    do_flush();
    chk(word_valid && word_out == 32'h45000000, "R7 padded partial word", word_out, 32'h45000000);
    drain_check("R4/R7 straddle pending");
  endtask

  task automatic t_zero_len();
    int s0;
    send(16, 32'hBEEF);
    s0 = seen;
    send(0, 32'hFFFFFFFF);
    chk(word_valid == 1'b0 && seen == s0, "R5 zero length emits nothing", 32'(seen - s0), 32'h0);
    send(16, 32'hCAFE);
    chk(word_out == 32'hBEEFCAFE, "R5 zero length left position alone", word_out, 32'hBEEFCAFE);
    drain_check("R5 pending");
  endtask

  task automatic t_high_bits();
    send(3, 32'hFFFFFFF5);
    send(29, 32'h0);
    chk(word_out == 32'hA0000000, "R6 bits above length ignored", word_out, 32'hA0000000);
    drain_check("R6 pending");
  endtask

  task automatic t_len32();
    send(5, 32'h1F);
    send(32, 32'h0F0F0F0F);
    chk(word_valid && word_out == 32'hF8787878, "R10 32-bit code at offset", word_out, 32'hF8787878);
    do_flush();
    chk(word_valid && word_out == 32'h78000000, "R10 remainder after 32-bit code", word_out, 32'h78000000);
    send(32, 32'h13579BDF);
    chk(word_valid && word_out == 32'h13579BDF, "R10 aligned 32-bit code", word_out, 32'h13579BDF);
    drain_check("R10 pending");
  endtask

  task automatic t_collide();
    int s0;
    send(8, 32'hA5);
    s0 = seen;
    flush = 1'b1;
    send(8, 32'h3C);
    flush = 1'b0;
    #1;
    chk(word_valid == 1'b0 && seen == s0, "R9 flush with codeword ignored", 32'(seen - s0), 32'h0);
    do_flush();
    chk(word_valid && word_out == 32'hA53C0000, "R9 both codes kept after ignored flush", word_out, 32'hA53C0000);
    drain_check("R9 pending");
  endtask

  task automatic t_idle();
    int s0;
    send(12, 32'h321);
    s0 = seen;
    repeat (10) @(negedge clk);
    chk(seen == s0, "R11 idle emits nothing", 32'(seen - s0), 32'h0);
    send(20, 32'h0);
    chk(word_out == 32'h32100000, "R11 position held across idle", word_out, 32'h32100000);
    drain_check("R11 pending");
  endtask

  task automatic t_mixed();
    logic [31:0] lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(int'(lfsr[5:0]) % 33, {lfsr[15:0], lfsr[31:16]});
      if (lfsr[9:6] == 4'h0) do_flush();
    end
    do_flush();
    drain_check("R2/R3/R4 mixed stream pending");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_straddle();
    t_zero_len();
    t_high_bits();
    t_len32();
    t_collide();
    t_idle();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule